// File: doc/BRIEF.md
# Multi-Register Transfer Address Sequencer

This block turns one block-transfer command into a stream of single-word memory accesses. A command carries a base address, a 16-bit register mask and five control bits: direction (up or down), pre/post stepping, base writeback, load or store, and a status bit. The set mask bits are walked from the lowest register index to the highest. Each access presents an address, a register index, a write enable and a sequential/non-sequential marker to an external memory port, which accepts it with a grant.

On loads, the returned word goes straight to the register-file write port. On stores, the register-file read value goes straight to memory, with three exceptions. Register 15 is replaced by the instruction address plus 12. The base register is replaced by the original base when it is the first register transferred, and by the final base otherwise. An empty list still writes the program counter slot.

The block also produces the base writeback, a user-bank override for the duration of the burst, a status-restore pulse, an error for the status bit in an unprivileged mode, a trailing idle cycle on loads, and a done pulse.

Top module: `multi_xfer_seq`

## Requirements
- R1: For a non-empty mask, exactly one granted access is made per set bit, and reg_idx_o takes the set indices in increasing order.
- R2: With n set bits, the lowest address is the base when up_i=1 and the base minus 4n when up_i=0. The effective stepping is pre_i when up=1 and the inverse of pre_i when up=0. The k-th access (k from 0) is at lowest + 4k, plus 4 more when the effective stepping is pre.
- R3: The first access of a burst has mem_seq_o=0. Every later access of the same burst has mem_seq_o=1.
- R4: Store data is reg_rdata_i, with these substitutions. Base index: the original base if it is the first register of the list, else the base plus 4n (up) or minus 4n (down). This rule takes precedence. Index 15: insn_addr_i+12.
- R5: Loads drive mem_we_o=0 and pulse reg_we_o with reg_wdata_o equal to mem_rdata_i on each granted access. Stores drive mem_we_o=1 and never assert reg_we_o.
- R6: Writeback happens only when wb_i=1. For a non-empty down list it is a single wb_en_o pulse in the first cycle after the start, carrying base-4n. For a non-empty up list it is a single pulse with done_o, carrying base+4n. That final pulse is cancelled on a load whose mask contains the base index.
- R7: An empty mask makes one access with index 15. A load goes to the base and writes mem_rdata_i with bits [1:0] cleared. A store writes insn_addr_i+12 at base-0x3C (down, post), base-0x40 (down, pre), base (up, post) or base+4 (up, pre). With wb_i, the base becomes base+0x40 (up) or base-0x40 (down) at done.
- R8: With psr_i=1, a load whose mask contains index 15 pulses psr_restore_o together with done_o and leaves reg_user_o low. Every other psr_i=1 command holds reg_user_o high on every access.
- R9: start_i with psr_i=1 and priv_i=0 raises err_o in that cycle. No access, done or writeback follows.
- R10: A load ends with one cycle of idle_o=1 and then done_o. A store raises done_o in the cycle after its last granted access.
- R11: While mem_req_o is high and mem_gnt_i is low, the address, index and write enable hold.
- R12: After reset: busy_o, mem_req_o, done_o, wb_en_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | command strobe, taken when idle |
| base_i | input | 32 | base register value |
| base_idx_i | input | 4 | index of the base register |
| rlist_i | input | 16 | register mask |
| up_i | input | 1 | 1 = addresses grow from base |
| pre_i | input | 1 | 1 = step before the access |
| wb_i | input | 1 | write the new base back |
| load_i | input | 1 | 1 = load, 0 = store |
| psr_i | input | 1 | status/user-bank bit |
| priv_i | input | 1 | current mode is privileged |
| insn_addr_i | input | 32 | address of the transfer instruction |
| busy_o | output | 1 | command in progress |
| err_o | output | 1 | status bit used in an unprivileged mode |
| mem_req_o | output | 1 | access request |
| mem_gnt_i | input | 1 | access accepted this cycle |
| mem_addr_o | output | 32 | access address |
| mem_we_o | output | 1 | store access |
| mem_seq_o | output | 1 | sequential access |
| mem_wdata_o | output | 32 | store data |
| mem_rdata_i | input | 32 | load data, valid with grant |
| reg_idx_o | output | 4 | register being transferred |
| reg_user_o | output | 1 | access the user register bank |
| reg_rdata_i | input | 32 | register-file read data for reg_idx_o |
| reg_we_o | output | 1 | register-file write |
| reg_wdata_o | output | 32 | register-file write data |
| idle_o | output | 1 | trailing internal cycle of a load |
| done_o | output | 1 | command complete |
| wb_en_o | output | 1 | base writeback strobe |
| wb_val_o | output | 32 | base writeback value |
| psr_restore_o | output | 1 | copy saved status into current status |

## Verification
The base-store substitution is the hardest case to reach. It depends on three things at once: whether the base index is the lowest set bit, a later set bit, or absent; the direction; and whether index 15 is also present. The sweep crosses sixteen masks chosen to put single bits, both ends, sparse and full patterns under base indices 0, 4 and 15, so each of these positions occurs in both directions. A grant that drops one cycle in four stalls accesses at every position in the burst.

// File: rtl/mx_pkg.sv
package mx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_TAIL = 2'd2,
    ST_FIN  = 2'd3
  } mx_state_e;
endpackage

// File: rtl/mx_popcount.sv
module mx_popcount #(
  parameter int N = 16,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec_i,
  output logic [W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) cnt_o = cnt_o + W'(vec_i[i]);
  end
endmodule

// File: rtl/mx_lowest.sv
module mx_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  oh_o,
  output logic [IW-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_pick
    assign seen[g+1] = seen[g] | vec_i[g];
    assign oh_o[g]   = vec_i[g] & ~seen[g];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) if (oh_o[i]) idx_o = idx_o | IW'(i);
  end
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
  import mx_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = $clog2(NREG + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic [NREG-1:0] rlist_i,
  input  logic            up_i,
  input  logic            pre_i,
  input  logic            wb_i,
  input  logic            load_i,
  input  logic            psr_i,
  input  logic            priv_i,
  input  logic [AW-1:0]   insn_addr_i,
  output logic            busy_o,
  output logic            err_o,
  output logic            mem_req_o,
  input  logic            mem_gnt_i,
  output logic [AW-1:0]   mem_addr_o,
  output logic            mem_we_o,
  output logic            mem_seq_o,
  output logic [AW-1:0]   mem_wdata_o,
  input  logic [AW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   reg_idx_o,
  output logic            reg_user_o,
  input  logic [AW-1:0]   reg_rdata_i,
  output logic            reg_we_o,
  output logic [AW-1:0]   reg_wdata_o,
  output logic            idle_o,
  output logic            done_o,
  output logic            wb_en_o,
  output logic [AW-1:0]   wb_val_o,
  output logic            psr_restore_o
);
  localparam logic [AW-1:0] SPAN     = AW'(4 * NREG);
  localparam logic [AW-1:0] SPAN_M1  = AW'(4 * (NREG - 1));
  localparam logic [IW-1:0] PC_IDX   = IW'(NREG - 1);
  localparam logic [AW-1:0] PC_AHEAD = AW'(12);

  mx_state_e state_q;
  logic [NREG-1:0] rem_q;
  logic [AW-1:0]   addr_q, base_q, nb_q, fin_val_q, insn_q;
  logic [IW-1:0]   bidx_q;
  logic up_q, load_q, empty_q, first_q, early_q, fin_wb_q, restore_q, user_q;

  // command decode
  logic [CW-1:0]   cnt_w;
  logic [AW-1:0]   nb_w, lo_w, first_w, eoff_w, fin_w;
  logic            empty_w, pre_eff_w, bad_w, accept_w;

  mx_popcount #(.N(NREG), .W(CW)) u_cnt (.vec_i(rlist_i), .cnt_o(cnt_w));

  always_comb begin
    empty_w   = (rlist_i == '0);
    nb_w      = AW'(cnt_w) << 2;
    pre_eff_w = up_i ? pre_i : ~pre_i;
    lo_w      = up_i ? base_i : base_i - nb_w;
    unique case ({up_i, pre_i})
      2'b00:   eoff_w = -SPAN_M1;
      2'b01:   eoff_w = -SPAN;
      2'b10:   eoff_w = '0;
      default: eoff_w = AW'(4);
    endcase
    if (empty_w) first_w = load_i ? base_i : base_i + eoff_w;
    else         first_w = lo_w + (pre_eff_w ? AW'(4) : '0);
    if (empty_w) fin_w = up_i ? base_i + SPAN : base_i - SPAN;
    else         fin_w = base_i + nb_w;
  end

  assign bad_w    = psr_i & ~priv_i;
  assign accept_w = start_i & (state_q == ST_IDLE) & ~bad_w;
  assign err_o    = start_i & (state_q == ST_IDLE) & bad_w;

  // walk
  logic [NREG-1:0] oh_w;
  logic [IW-1:0]   pick_w;
  logic            last_w, fire_w;

  mx_lowest #(.N(NREG), .IW(IW)) u_pick (.vec_i(rem_q), .oh_o(oh_w), .idx_o(pick_w));

  assign last_w = empty_q | ((rem_q & ~oh_w) == '0);
  assign fire_w = mem_req_o & mem_gnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      addr_q    <= '0;
      base_q    <= '0;
      nb_q      <= '0;
      fin_val_q <= '0;
      insn_q    <= '0;
      bidx_q    <= '0;
      up_q      <= 1'b0;
      load_q    <= 1'b0;
      empty_q   <= 1'b0;
      first_q   <= 1'b0;
      early_q   <= 1'b0;
      fin_wb_q  <= 1'b0;
      restore_q <= 1'b0;
      user_q    <= 1'b0;
    end else begin
      early_q <= accept_w & wb_i & ~up_i & ~empty_w;
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q   <= ST_XFER;
          rem_q     <= rlist_i;
          addr_q    <= first_w;
          base_q    <= base_i;
          nb_q      <= nb_w;
          fin_val_q <= fin_w;
          insn_q    <= insn_addr_i;
          bidx_q    <= base_idx_i;
          up_q      <= up_i;
          load_q    <= load_i;
          empty_q   <= empty_w;
          first_q   <= 1'b1;
          fin_wb_q  <= wb_i & (empty_w | (up_i & ~(load_i & rlist_i[base_idx_i])));
          restore_q <= psr_i & load_i & rlist_i[NREG-1];
          user_q    <= psr_i & ~(load_i & rlist_i[NREG-1]);
        end
        ST_XFER: if (fire_w) begin
          rem_q   <= rem_q & ~oh_w;
          addr_q  <= addr_q + AW'(4);
          first_q <= 1'b0;
          if (last_w) state_q <= load_q ? ST_TAIL : ST_FIN;
        end
        ST_TAIL: state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // outputs
  logic xfer_w;
  assign xfer_w     = (state_q == ST_XFER);
  assign busy_o     = (state_q != ST_IDLE);
  assign mem_req_o  = xfer_w;
  assign mem_addr_o = addr_q;
  assign mem_we_o   = xfer_w & ~load_q;
  assign mem_seq_o  = xfer_w & ~first_q;
  assign reg_idx_o  = empty_q ? PC_IDX : pick_w;
  assign reg_user_o = busy_o & user_q;
  assign reg_we_o   = fire_w & load_q;
  assign reg_wdata_o = empty_q ? {mem_rdata_i[AW-1:2], 2'b00} : mem_rdata_i;
  assign idle_o     = (state_q == ST_TAIL);
  assign done_o     = (state_q == ST_FIN);
  assign psr_restore_o = done_o & restore_q;
  assign wb_en_o    = early_q | (done_o & fin_wb_q);
  assign wb_val_o   = early_q ? base_q - nb_q : fin_val_q;

  always_comb begin
    if (empty_q)                 mem_wdata_o = insn_q + PC_AHEAD;
    else if (reg_idx_o == bidx_q)
      mem_wdata_o = first_q ? base_q : (up_q ? base_q + nb_q : base_q - nb_q);
    else if (reg_idx_o == PC_IDX) mem_wdata_o = insn_q + PC_AHEAD;
    else                         mem_wdata_o = reg_rdata_i;
  end

  // R3
  first_nonseq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_seq_o);
  // R3
  later_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !done_o) |=> (!mem_req_o || mem_seq_o));
  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(4)));
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(reg_idx_o)
                                   && $stable(mem_we_o)));
  // R10
  idle_then_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |=> done_o);
  // R9
  err_no_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !busy_o);
  // R8
  restore_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psr_restore_o |-> (done_o && !reg_user_o));
  // R5
  no_store_rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !reg_we_o);
endmodule

// File: tb/tb_multi_xfer_seq.sv
`timescale 1ns/1ps
module tb_multi_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [15:0] rlist_i = '0;
  logic        up_i = 1'b0, pre_i = 1'b0, wb_i = 1'b0, load_i = 1'b0, psr_i = 1'b0;
  logic        priv_i = 1'b1;
  logic [31:0] insn_addr_i = 32'h0800_0400;
  logic        busy_o, err_o, mem_req_o, mem_we_o, mem_seq_o;
  logic        mem_gnt_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, reg_rdata_i, reg_wdata_o, wb_val_o;
  logic [3:0]  reg_idx_o;
  logic        reg_user_o, reg_we_o, idle_o, done_o, wb_en_o, psr_restore_o;

  int checks = 0, fails = 0, cyc_n = 0;

  always #2 clk_i = ~clk_i;

  assign mem_rdata_i = 32'h1000_0003 ^ mem_addr_o;
  assign reg_rdata_i = 32'hA5A5_0000 | {28'h0, reg_idx_o};

  multi_xfer_seq dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic run(input logic [15:0] rl, input logic [3:0] bi, input bit up, input bit pre,
                     input bit wb, input bit ld, input bit ps);
    logic [31:0] base, nb, lo, a_exp, d_exp, wb_exp;
    int n, k, wbs, ncyc, r;
    bit pe, empty, saw_idle, fin_wb, early, user;
    int idx_list[16];
    base = 32'h2000_0100 + {20'h0, bi, 8'h0};
    n = popc(rl);
    empty = (rl == 0);
    nb = 32'(4 * n);
    lo = up ? base : base - nb;
    pe = up ? pre : !pre;
    r = 0;
    for (int i = 0; i < 16; i++) if (rl[i]) begin idx_list[r] = i; r++; end
    early  = wb && !up && !empty;
    fin_wb = wb && (empty || (up && !(ld && rl[bi])));
    user   = ps && !(ld && rl[15]);
    @(negedge clk_i);
    start_i = 1'b1; base_i = base; base_idx_i = bi; rlist_i = rl;
    up_i = up; pre_i = pre; wb_i = wb; load_i = ld; psr_i = ps; priv_i = 1'b1;
    mem_gnt_i = 1'b0;
    k = 0; wbs = 0; ncyc = 0; saw_idle = 0;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      cyc_n++; ncyc++;
      mem_gnt_i = (cyc_n % 4) != 3;
      #0.5;
      if (wb_en_o) begin
        wbs++;
        // R6
        if (early) begin
          check(ncyc == 1 && wb_val_o == base - nb, "R6 early wb", wb_val_o, base - nb);
        end else begin
          wb_exp = empty ? (up ? base + 32'h40 : base - 32'h40) : base + nb;
          check(done_o && wb_val_o == wb_exp, "R6/R7 final wb", wb_val_o, wb_exp);
        end
      end
      if (mem_req_o && mem_gnt_i) begin
        if (empty) begin
          if (ld) a_exp = base;
          else case ({up, pre})
            2'b00: a_exp = base - 32'h3C;
            2'b01: a_exp = base - 32'h40;
            2'b10: a_exp = base;
            default: a_exp = base + 32'h4;
          endcase
          check(k == 0 && reg_idx_o == 4'd15 && mem_addr_o == a_exp, "R7 empty access",
                mem_addr_o, a_exp);
          if (ld) check(reg_we_o && reg_wdata_o == ((32'h1000_0003 ^ a_exp) & ~32'h3),
                        "R7 empty load data", reg_wdata_o, (32'h1000_0003 ^ a_exp) & ~32'h3);
          else check(mem_we_o && mem_wdata_o == insn_addr_i + 12, "R7 empty store data",
                     mem_wdata_o, insn_addr_i + 12);
        end else begin
          a_exp = lo + 32'(4 * k) + (pe ? 32'h4 : 32'h0);
          // R1
          check(k < n && int'(reg_idx_o) == idx_list[k], "R1 order",
                {28'h0, reg_idx_o}, 32'(idx_list[k < n ? k : 0]));
          // R2
          check(mem_addr_o == a_exp, "R2 address", mem_addr_o, a_exp);
          if (ld) begin
            check(!mem_we_o && reg_we_o && reg_wdata_o == mem_rdata_i, "R5 load path",
                  reg_wdata_o, mem_rdata_i);
          end else begin
            if (reg_idx_o == bi) d_exp = (k == 0) ? base : (up ? base + nb : base - nb);
            else if (reg_idx_o == 4'd15) d_exp = insn_addr_i + 12;
            else d_exp = 32'hA5A5_0000 | {28'h0, reg_idx_o};
            // R4
            check(mem_we_o && !reg_we_o && mem_wdata_o == d_exp, "R4/R5 store data",
                  mem_wdata_o, d_exp);
          end
        end
        // R3
        check(mem_seq_o == (k != 0), "R3 seq flag", {31'h0, mem_seq_o}, {31'h0, k != 0});
        // R8
        check(reg_user_o == user, "R8 user bank", {31'h0, reg_user_o}, {31'h0, user});
        k++;
      end
      if (idle_o) saw_idle = 1;
      if (done_o) begin
        check(k == (empty ? 1 : n), "R1 access count", 32'(k), 32'(empty ? 1 : n));
        // R10
        check(saw_idle == ld, "R10 trailing idle", {31'h0, saw_idle}, {31'h0, ld});
        // R8
        check(psr_restore_o == (ps && ld && rl[15]), "R8 restore", {31'h0, psr_restore_o},
              {31'h0, ps && ld && rl[15]});
        // R6
        check(wbs == int'(early || fin_wb), "R6 wb count", 32'(wbs), 32'(early || fin_wb));
        break;
      end
      if (ncyc > 100) begin
        check(0, "watchdog", 32'(ncyc), 32'd100);
        break;
      end
    end
    @(negedge clk_i);
    mem_gnt_i = 1'b0;
  endtask

  initial begin : watchdog
    #(4ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] pats[16];
    logic [3:0]  bis[3];
    pats = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h8001, 16'h00F0, 16'hAAAA, 16'h5555,
             16'h0102, 16'h4000, 16'h7FFE, 16'h1248, 16'h8421, 16'h0003, 16'hC000, 16'h0810};
    bis = '{4'd0, 4'd4, 4'd15};
    repeat (3) @(negedge clk_i);
    // R12
    check(!busy_o && !mem_req_o && !done_o && !wb_en_o && !err_o, "R12 reset",
          {27'h0, busy_o, mem_req_o, done_o, wb_en_o, err_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9
    start_i = 1'b1; psr_i = 1'b1; priv_i = 1'b0; rlist_i = 16'h00FF; load_i = 1'b1; wb_i = 1'b1;
    #0.5;
    check(err_o, "R9 err pulse", {31'h0, err_o}, 32'h1);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #0.5;
      check(!busy_o && !mem_req_o && !done_o && !wb_en_o, "R9 no burst",
            {28'h0, busy_o, mem_req_o, done_o, wb_en_o}, 32'h0);
      @(negedge clk_i);
    end
    priv_i = 1'b1;

    // R11: hold during a long stall
    @(negedge clk_i);
    start_i = 1'b1; rlist_i = 16'h0006; psr_i = 1'b0; up_i = 1'b1; pre_i = 1'b0;
    load_i = 1'b0; base_i = 32'h3000_0000; base_idx_i = 4'd9; mem_gnt_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      #0.5;
      check(mem_req_o && mem_addr_o == 32'h3000_0000 && reg_idx_o == 4'd1 && mem_we_o,
            "R11 stall hold", mem_addr_o, 32'h3000_0000);
    end
    mem_gnt_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    mem_gnt_i = 1'b0;
    repeat (3) @(negedge clk_i);

    for (int p = 0; p < 16; p++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 32; m++)
          run(pats[p], bis[b], m[0], m[1], m[2], m[3], m[4]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule